// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the register-bus face of a serial port. A processor reaches it through a simple bus with an address, a write strobe with write data, and a read strobe with registered read data. The block stores line, control, FIFO, modem and baud-divisor settings. It hands each written transmit byte to a byte-wide output with a one-cycle valid strobe. It takes received bytes from a byte-wide valid/ready input into a single holding slot. Bit timing, baud generation, real FIFOs, modem lines and error detection are left to other logic. The baud divisor is only stored and read back.

Three control bits set how the port behaves. One bit turns on an internal loopback, which sends transmit bytes straight into the receive slot and not to the output. The other two bits pick, for each direction, whether the interrupt is a one-cycle pulse or a sticky level. The level stays up until software reads the byte or rewrites the control register. Every output is a register, so each result appears one clock after the stimulus that causes it. The only exception is the receive ready signal, which is combinational.

Top module: `serport_ctrl_front`

## Requirements
- R1: Synchronous active-high reset clears every stored register, the holding slot, the receive-available flag, read data and all four interrupt outputs. After reset, rx_in_ready is high and the status register at offset 0x10 reads 0x6.
- R2: The line control (0x00), general control (0x04) and baud divisor (0x28) registers read back the full written word. Read data appears one clock after the read strobe. Only the low 6 address bits are decoded.
- R3: A write to FIFO control (0x08) stores the value with bits 1 and 2 cleared, and a read of it also clears bit 3. Writing 0xFF therefore reads back 0xF1.
- R4: A read of modem control (0x0C) returns the stored value ANDed with 0x11.
- R5: Status 0x10 reads 0x6 with bit 0 equal to receive-available. Offset 0x18 reads receive-available alone. Offsets 0x14, 0x1C and 0x20, and every unmapped offset, read zero.
- R6: Writes to 0x10, 0x14, 0x18, 0x1C and 0x24 change no state: status values and the held byte are unchanged afterwards.
- R7: When control bit 5 is 0, a write to 0x20 puts write-data bits 7:0 on tx_byte, with tx_valid high for exactly the next clock cycle.
- R8: When control bit 5 is 1, a write to 0x20 loads write-data bits 7:0 into the holding slot and sets receive-available. tx_valid stays low.
- R9: When a byte enters the holding slot, irq_rx_level rises if control bit 8 is 1. Otherwise irq_rx_pulse is high for exactly one cycle.
- R10: Every write to 0x20 raises irq_tx_level if control bit 9 is 1. Otherwise irq_tx_pulse is high for exactly one cycle.
- R11: A write to general control sets irq_tx_level to write-data bit 9, and clears irq_rx_level when write-data bit 8 is 0. That clear takes priority over a receive-level set in the same cycle.
- R12: A read of 0x24 returns the held byte and clears receive-available. If control bit 8 is 1, the read also drops irq_rx_level.
- R13: rx_in_ready is high only while no byte is held. An accepted byte is held unchanged while further input is refused.
- R14: If a loopback write to 0x20 and an external byte arrive in the same cycle, the loopback byte is stored. rx_in_ready is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| tx_byte | output | BYTE_W | Transmit byte |
| tx_valid | output | 1 | Transmit byte valid, one cycle |
| rx_in_data | input | BYTE_W | External receive byte |
| rx_in_valid | input | 1 | External receive byte valid |
| rx_in_ready | output | 1 | Holding slot can take a byte |
| irq_rx_pulse | output | 1 | Receive interrupt, pulse mode |
| irq_rx_level | output | 1 | Receive interrupt, level mode |
| irq_tx_pulse | output | 1 | Transmit interrupt, pulse mode |
| irq_tx_level | output | 1 | Transmit interrupt, level mode |

## Verification
Read data, tx_byte/tx_valid and all four interrupt outputs change at the clock edge that captures the strobe. The receive-available flag changes at that same edge, so a status read issued on the next cycle already shows the new value. The bench drives each strobe for one cycle starting on a falling edge, and samples results on the falling edge that follows the capturing rising edge. It then samples once more a cycle later to confirm that pulses and tx_valid have dropped. rx_in_ready is combinational, so it is checked in the middle of the cycle in which the stimulus is applied.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int DEC_W = 6;

  localparam logic [DEC_W-1:0] OFS_LINE  = 6'h00;
  localparam logic [DEC_W-1:0] OFS_CTRL  = 6'h04;
  localparam logic [DEC_W-1:0] OFS_FIFO  = 6'h08;
  localparam logic [DEC_W-1:0] OFS_MODEM = 6'h0C;
  localparam logic [DEC_W-1:0] OFS_STAT  = 6'h10;
  localparam logic [DEC_W-1:0] OFS_ERR   = 6'h14;
  localparam logic [DEC_W-1:0] OFS_FSTAT = 6'h18;
  localparam logic [DEC_W-1:0] OFS_MSTAT = 6'h1C;
  localparam logic [DEC_W-1:0] OFS_TXH   = 6'h20;
  localparam logic [DEC_W-1:0] OFS_RXH   = 6'h24;
  localparam logic [DEC_W-1:0] OFS_BAUD  = 6'h28;

  // control register bit positions
  localparam int CB_LOOP  = 5;
  localparam int CB_RXLVL = 8;
  localparam int CB_TXLVL = 9;

  // index of each stored configuration register
  typedef enum logic [2:0] {
    CFG_LINE  = 3'd0,
    CFG_CTRL  = 3'd1,
    CFG_FIFO  = 3'd2,
    CFG_MODEM = 3'd3,
    CFG_BAUD  = 3'd4
  } cfg_idx_e;

  localparam int NUM_CFG = 5;

  typedef struct packed {
    logic loop_en;
    logic rx_lvl;
    logic tx_lvl;
  } mode_bits_t;
endpackage

// File: rtl/serport_cfg_regs.sv
module serport_cfg_regs
  import serport_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_CFG-1:0]        wr_sel,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q
);
  // bits kept on write, per register
  function automatic logic [DATA_W-1:0] keep_mask(int idx);
    logic [DATA_W-1:0] m;
    m = '1;
    if (idx == int'(CFG_FIFO)) begin
      m[1] = 1'b0;
      m[2] = 1'b0;
    end
    return m;
  endfunction

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
    localparam logic [DATA_W-1:0] KEEP = keep_mask(g);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_sel[g]) begin
        cfg_q[g] <= wdata & KEEP;
      end
    end
  end
endmodule

// File: rtl/serport_rx_slot.sv
module serport_rx_slot #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lb_load,
  input  logic [BYTE_W-1:0] lb_data,
  input  logic              ext_valid,
  input  logic [BYTE_W-1:0] ext_data,
  input  logic              take,
  output logic              ext_ready,
  output logic              load_evt,
  output logic              avail_q,
  output logic [BYTE_W-1:0] held_q
);
  logic accept;

  assign ext_ready = ~avail_q & ~lb_load;
  assign accept    = ext_valid & ext_ready;
  assign load_evt  = lb_load | accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      avail_q <= 1'b0;
      held_q  <= '0;
    end else if (load_evt) begin
      avail_q <= 1'b1;
      held_q  <= lb_load ? lb_data : ext_data;
    end else if (take) begin
      avail_q <= 1'b0;
    end
  end
endmodule

// File: rtl/serport_irq.sv
module serport_irq
  import serport_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  mode_bits_t mode,
  input  logic       rx_load,
  input  logic       rx_take,
  input  logic       ctl_wr,
  input  logic       ctl_rx_lvl_new,
  input  logic       ctl_tx_lvl_new,
  input  logic       tx_wr,
  output logic       rx_pulse,
  output logic       rx_level,
  output logic       tx_pulse,
  output logic       tx_level
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_pulse <= 1'b0;
      rx_level <= 1'b0;
      tx_pulse <= 1'b0;
      tx_level <= 1'b0;
    end else begin
      rx_pulse <= rx_load & ~mode.rx_lvl;
      tx_pulse <= tx_wr & ~mode.tx_lvl;

      if (ctl_wr && !ctl_rx_lvl_new) begin
        rx_level <= 1'b0;
      end else if (rx_load && mode.rx_lvl) begin
        rx_level <= 1'b1;
      end else if (rx_take && mode.rx_lvl) begin
        rx_level <= 1'b0;
      end

      if (ctl_wr) begin
        tx_level <= ctl_tx_lvl_new;
      end else if (tx_wr && mode.tx_lvl) begin
        tx_level <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/serport_ctrl_front.sv
module serport_ctrl_front
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  input  logic [BYTE_W-1:0] rx_in_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  output logic              irq_rx_pulse,
  output logic              irq_rx_level,
  output logic              irq_tx_pulse,
  output logic              irq_tx_level
);
  localparam logic [DATA_W-1:0] FIFO_RD_KEEP  = ~(DATA_W'(1) << 3);
  localparam logic [DATA_W-1:0] MODEM_RD_KEEP = DATA_W'(32'h11);
  localparam logic [DATA_W-1:0] STAT_FIXED    = DATA_W'(32'h6);

  logic [DEC_W-1:0] dec_addr;
  logic [NUM_CFG-1:0] cfg_wr;
  logic [NUM_CFG-1:0][DATA_W-1:0] cfg_q;
  mode_bits_t mode;
  logic txh_wr, lb_load, rx_take, load_evt, avail_q;
  logic [BYTE_W-1:0] held_q;
  logic [DATA_W-1:0] rd_mux;

  assign dec_addr = bus_addr[DEC_W-1:0];

  assign cfg_wr[CFG_LINE]  = bus_wr && dec_addr == OFS_LINE;
  assign cfg_wr[CFG_CTRL]  = bus_wr && dec_addr == OFS_CTRL;
  assign cfg_wr[CFG_FIFO]  = bus_wr && dec_addr == OFS_FIFO;
  assign cfg_wr[CFG_MODEM] = bus_wr && dec_addr == OFS_MODEM;
  assign cfg_wr[CFG_BAUD]  = bus_wr && dec_addr == OFS_BAUD;

  assign mode.loop_en = cfg_q[CFG_CTRL][CB_LOOP];
  assign mode.rx_lvl  = cfg_q[CFG_CTRL][CB_RXLVL];
  assign mode.tx_lvl  = cfg_q[CFG_CTRL][CB_TXLVL];

  assign txh_wr  = bus_wr && dec_addr == OFS_TXH;
  assign lb_load = txh_wr && mode.loop_en;
  assign rx_take = bus_rd && dec_addr == OFS_RXH;

  serport_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr_sel(cfg_wr),
    .wdata (bus_wdata),
    .cfg_q (cfg_q)
  );

  serport_rx_slot #(.BYTE_W(BYTE_W)) u_slot (
    .clk      (clk),
    .rst      (rst),
    .lb_load  (lb_load),
    .lb_data  (bus_wdata[BYTE_W-1:0]),
    .ext_valid(rx_in_valid),
    .ext_data (rx_in_data),
    .take     (rx_take),
    .ext_ready(rx_in_ready),
    .load_evt (load_evt),
    .avail_q  (avail_q),
    .held_q   (held_q)
  );

  serport_irq u_irq (
    .clk           (clk),
    .rst           (rst),
    .mode          (mode),
    .rx_load       (load_evt),
    .rx_take       (rx_take),
    .ctl_wr        (cfg_wr[CFG_CTRL]),
    .ctl_rx_lvl_new(bus_wdata[CB_RXLVL]),
    .ctl_tx_lvl_new(bus_wdata[CB_TXLVL]),
    .tx_wr         (txh_wr),
    .rx_pulse      (irq_rx_pulse),
    .rx_level      (irq_rx_level),
    .tx_pulse      (irq_tx_pulse),
    .tx_level      (irq_tx_level)
  );

  always_comb begin
    case (dec_addr)
      OFS_LINE:  rd_mux = cfg_q[CFG_LINE];
      OFS_CTRL:  rd_mux = cfg_q[CFG_CTRL];
      OFS_FIFO:  rd_mux = cfg_q[CFG_FIFO] & FIFO_RD_KEEP;
      OFS_MODEM: rd_mux = cfg_q[CFG_MODEM] & MODEM_RD_KEEP;
      OFS_STAT:  rd_mux = STAT_FIXED | DATA_W'(avail_q);
      OFS_FSTAT: rd_mux = DATA_W'(avail_q);
      OFS_RXH:   rd_mux = DATA_W'(held_q);
      OFS_BAUD:  rd_mux = cfg_q[CFG_BAUD];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_byte   <= '0;
      tx_valid  <= 1'b0;
    end else begin
      if (bus_rd) begin
        bus_rdata <= rd_mux;
      end
      tx_valid <= txh_wr & ~mode.loop_en;
      if (txh_wr && !mode.loop_en) begin
        tx_byte <= bus_wdata[BYTE_W-1:0];
      end
    end
  end
endmodule

// File: rtl/serport_ctrl_chk.sv
module serport_ctrl_chk
  import serport_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tx_valid,
  input logic              rx_in_valid,
  input logic              rx_in_ready,
  input logic              irq_rx_level,
  input logic              irq_tx_pulse,
  input logic              irq_tx_level,
  input logic              loop_mode
);
  logic wr_txh, wr_ctl;
  assign wr_txh = bus_wr && bus_addr[DEC_W-1:0] == OFS_TXH;
  assign wr_ctl = bus_wr && bus_addr[DEC_W-1:0] == OFS_CTRL;

  AST_TXV_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> $past(wr_txh && !loop_mode)); // R7
  AST_LOOP_NO_TXV: assert property (@(posedge clk) disable iff (rst)
    (wr_txh && loop_mode) |=> !tx_valid); // R8
  AST_TXP_FROM_WRITE: assert property (@(posedge clk) disable iff (rst)
    irq_tx_pulse |-> $past(wr_txh)); // R10
  AST_TXL_TRACKS_CTL: assert property (@(posedge clk) disable iff (rst)
    wr_ctl |=> (irq_tx_level == $past(bus_wdata[CB_TXLVL]))); // R11
  AST_RXL_CLR_BY_CTL: assert property (@(posedge clk) disable iff (rst)
    (wr_ctl && !bus_wdata[CB_RXLVL]) |=> !irq_rx_level); // R11
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (rst)
    (rx_in_valid && rx_in_ready) |=> !rx_in_ready); // R13
  AST_LOOP_BLOCKS_EXT: assert property (@(posedge clk) disable iff (rst)
    (wr_txh && loop_mode) |-> !rx_in_ready); // R14
endmodule

bind serport_ctrl_front serport_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_addr    (bus_addr),
  .bus_wr      (bus_wr),
  .bus_wdata   (bus_wdata),
  .tx_valid    (tx_valid),
  .rx_in_valid (rx_in_valid),
  .rx_in_ready (rx_in_ready),
  .irq_rx_level(irq_rx_level),
  .irq_tx_pulse(irq_tx_pulse),
  .irq_tx_level(irq_tx_level),
  .loop_mode   (mode.loop_en)
);

// File: tb/serport_ctrl_front_tb.sv
`timescale 1ns/1ps
module serport_ctrl_front_tb;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic [BW-1:0] tx_byte;
  logic tx_valid;
  logic [BW-1:0] rx_in_data = '0;
  logic rx_in_valid = 1'b0;
  logic rx_in_ready;
  logic irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  serport_ctrl_front #(.ADDR_W(AW), .DATA_W(DW), .BYTE_W(BW)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .rx_in_data(rx_in_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready),
    .irq_rx_pulse(irq_rx_pulse), .irq_rx_level(irq_rx_level),
    .irq_tx_pulse(irq_tx_pulse), .irq_tx_level(irq_tx_level)
  );

  // op(1: read, 0: write) | addr | data-or-expected | requirement number
  localparam int NV = 20;
  localparam logic [46:0] VEC [0:NV-1] = '{
    {1'b0, 6'h00, 32'h0000_002B, 8'd2},  // R2 line control
    {1'b1, 6'h00, 32'h0000_002B, 8'd2},
    {1'b0, 6'h28, 32'h0001_2345, 8'd2},  // R2 baud divisor
    {1'b1, 6'h28, 32'h0001_2345, 8'd2},
    {1'b0, 6'h08, 32'h0000_00FF, 8'd3},  // R3 fifo masks
    {1'b1, 6'h08, 32'h0000_00F1, 8'd3},
    {1'b0, 6'h0C, 32'hFFFF_FFFF, 8'd4},  // R4 modem mask
    {1'b1, 6'h0C, 32'h0000_0011, 8'd4},
    {1'b0, 6'h10, 32'h0000_FFFF, 8'd6},  // R6 status write ignored
    {1'b1, 6'h10, 32'h0000_0006, 8'd6},
    {1'b0, 6'h18, 32'h0000_00FF, 8'd6},
    {1'b1, 6'h18, 32'h0000_0000, 8'd6},
    {1'b0, 6'h14, 32'h0000_0001, 8'd6},
    {1'b1, 6'h14, 32'h0000_0000, 8'd5},  // R5 zero readers
    {1'b0, 6'h1C, 32'h0000_0001, 8'd6},
    {1'b1, 6'h1C, 32'h0000_0000, 8'd5},
    {1'b1, 6'h20, 32'h0000_0000, 8'd5},
    {1'b1, 6'h3C, 32'h0000_0000, 8'd5},
    {1'b0, 6'h04, 32'h0000_0C01, 8'd2},  // R2 control readback
    {1'b1, 6'h04, 32'h0000_0C01, 8'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic ext_send(input logic [BW-1:0] b, input logic exp_ready, input string req);
    @(negedge clk);
    rx_in_data = b; rx_in_valid = 1'b1;
    #1;
    check(req, 32'(rx_in_ready), 32'(exp_ready));
    @(negedge clk);
    rx_in_valid = 1'b0;
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 rdata", bus_rdata, 0);
    check("R1 tx_valid", 32'(tx_valid), 0);
    check("R1 irqs", {28'd0, irq_rx_pulse, irq_rx_level, irq_tx_pulse, irq_tx_level}, 0);
    check("R1 ready", 32'(rx_in_ready), 1);
    read_check("R1 status", 6'h10, 32'h6);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46]) begin
        bus_read(VEC[i][45:40], d);
        n_chk++;
        if (d !== VEC[i][39:8]) begin
          n_fail++;
          $display("FAIL R%0d vector %0d actual=0x%0h expected=0x%0h", VEC[i][7:0], i, d, VEC[i][39:8]);
        end
      end else begin
        bus_write(VEC[i][45:40], VEC[i][39:8]);
      end
    end
    // R2 only low 6 address bits decoded: restore control to zero
    bus_write(6'h04, 32'h0);
    read_check("R2 control cleared", 6'h04, 32'h0);

    // R7 / R10 pulse transmit
    bus_write(6'h20, 32'h0000_01A5);
    check("R7 tx_valid", 32'(tx_valid), 1);
    check("R7 tx_byte", 32'(tx_byte), 32'hA5);
    check("R10 tx pulse", 32'(irq_tx_pulse), 1);
    check("R10 tx level idle", 32'(irq_tx_level), 0);
    @(negedge clk);
    check("R7 tx_valid one cycle", 32'(tx_valid), 0);
    check("R10 tx pulse one cycle", 32'(irq_tx_pulse), 0);

    // R11 / R10 level transmit
    bus_write(6'h04, 32'h0000_0200);
    check("R11 tx level from ctl", 32'(irq_tx_level), 1);
    bus_write(6'h20, 32'h0000_0033);
    check("R7 tx byte", 32'(tx_byte), 32'h33);
    check("R10 no pulse in level mode", 32'(irq_tx_pulse), 0);
    check("R10 level held", 32'(irq_tx_level), 1);
    bus_write(6'h04, 32'h0);
    check("R11 tx level dropped", 32'(irq_tx_level), 0);

    // R13 / R9 external byte, pulse mode
    ext_send(8'h5C, 1'b1, "R13 ready when empty");
    check("R9 rx pulse", 32'(irq_rx_pulse), 1);
    check("R9 no rx level", 32'(irq_rx_level), 0);
    check("R13 ready low when held", 32'(rx_in_ready), 0);
    @(negedge clk);
    check("R9 rx pulse one cycle", 32'(irq_rx_pulse), 0);
    read_check("R5 status avail", 6'h10, 32'h7);
    read_check("R5 fifo count", 6'h18, 32'h1);
    bus_write(6'h24, 32'h0000_0077);
    ext_send(8'h99, 1'b0, "R13 refused while held");
    read_check("R6 status after rx write", 6'h10, 32'h7);
    read_check("R12 held byte", 6'h24, 32'h5C);
    read_check("R12 avail cleared", 6'h10, 32'h6);
    check("R13 ready after read", 32'(rx_in_ready), 1);

    // R8 / R9 / R12 loopback with level mode
    bus_write(6'h04, 32'h0000_0120);
    bus_write(6'h20, 32'h0000_004E);
    check("R8 no tx_valid in loopback", 32'(tx_valid), 0);
    check("R9 rx level", 32'(irq_rx_level), 1);
    check("R9 no rx pulse", 32'(irq_rx_pulse), 0);
    check("R10 tx pulse on loopback", 32'(irq_tx_pulse), 1);
    check("R8 slot full", 32'(rx_in_ready), 0);
    read_check("R12 loop byte", 6'h24, 32'h4E);
    check("R12 rx level dropped", 32'(irq_rx_level), 0);

    // R11 clear of rx level by control write with bit 8 = 0
    bus_write(6'h20, 32'h0000_0011);
    check("R9 rx level again", 32'(irq_rx_level), 1);
    bus_write(6'h04, 32'h0000_0020);
    check("R11 rx level cleared", 32'(irq_rx_level), 0);
    read_check("R11 byte still held", 6'h10, 32'h7);
    read_check("R12 byte", 6'h24, 32'h11);

    // R8 loopback pulse mode
    bus_write(6'h20, 32'h0000_0022);
    check("R8 rx pulse via loopback", 32'(irq_rx_pulse), 1);
    check("R8 no tx_valid", 32'(tx_valid), 0);
    read_check("R8 byte", 6'h24, 32'h22);

    // R14 collision: loopback wins
    @(negedge clk);
    bus_addr = 6'h20; bus_wdata = 32'h6D; bus_wr = 1'b1;
    rx_in_data = 8'h90; rx_in_valid = 1'b1;
    #1;
    check("R14 ready low on collision", 32'(rx_in_ready), 0);
    @(negedge clk);
    bus_wr = 1'b0; rx_in_valid = 1'b0;
    read_check("R14 loop byte kept", 6'h24, 32'h6D);

    // R1 mid-run reset
    bus_write(6'h04, 32'h0000_0300);
    ext_send(8'h44, 1'b1, "R13 accept before reset");
    check("R9 level before reset", 32'(irq_rx_level), 1);
    pulse_reset();
    #1;
    check("R1 tx level cleared", 32'(irq_tx_level), 0);
    check("R1 rx level cleared", 32'(irq_rx_level), 0);
    check("R1 ready after reset", 32'(rx_in_ready), 1);
    read_check("R1 control cleared", 6'h04, 32'h0);
    read_check("R1 status after reset", 6'h10, 32'h6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule